// File: doc/BRIEF.md
# DMA Error Status Capture

This block keeps a record of the most recent transfer fault seen by a multi-channel DMA engine. It watches three error sources. The first is a strobe for a bus error on a source read. The second is a strobe for a bus error on a destination write. The third is a descriptor-link check made when a scatter/gather operation begins after a major loop has finished.

When any of these fires, the block stores the fault in a status word. The stored word holds a one-hot fault type, the channel that was active and a valid bit. A later fault replaces the stored word completely, so the word always describes the newest fault only.

Software-side logic can read the word through a registered read port. It can also wipe the record with a one-cycle clear strobe. A copy of the live word is also driven out at all times.

Top module: `dma_err_status`

## Requirements
- R1: After reset, `status_o` and `rd_data_o` are all zero.
- R2: A destination-write error strobe alone sets `status_o` on the next edge to flag bit 0 only, the active channel in bits 11:8 and the valid bit 31. All other bits are zero.
- R3: A source-read error strobe alone sets flag bit 1 only, together with the channel in bits 11:8 and valid bit 31.
- R4: A scatter/gather start with its enable set and a link address whose low 5 bits are nonzero raises a configuration error. This sets flag bit 2 only, with the channel in bits 11:8 and valid bit 31.
- R5: A scatter/gather start with a 32-byte aligned link address, or with its enable clear, leaves `status_o` unchanged.
- R6: Each new fault overwrites the whole record. Afterwards exactly one of bits 2:0 is set, and valid is set exactly when a flag is set.
- R7: When several faults arrive in one cycle, only one is recorded. The configuration error beats the source error, and the source error beats the destination error.
- R8: A clear strobe with no fault in the same cycle sets `status_o` to zero on the next edge.
- R9: When a fault and a clear strobe arrive in the same cycle, the fault is recorded and the clear has no effect.
- R10: When `rd_en_i` is high at an edge, `rd_data_o` takes the value `status_o` had just before that edge. When `rd_en_i` is low, `rd_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_err_i | input | 1 | Bus error on a source read, one-cycle strobe |
| dst_err_i | input | 1 | Bus error on a destination write, one-cycle strobe |
| sg_start_i | input | 1 | Scatter/gather operation begins after a major loop |
| sg_en_i | input | 1 | Scatter/gather enable of the active channel |
| sg_link_i | input | ADDR_W | Next-descriptor link address |
| chan_i | input | 4 | Active channel number |
| clr_i | input | 1 | Clear the recorded fault, one-cycle strobe |
| rd_en_i | input | 1 | Read strobe for the status word |
| status_o | output | 32 | Live status word |
| rd_data_o | output | 32 | Registered read data |

## Verification
Two pairs of functions can collide in a single cycle. The first pair is a fault and a clear strobe. The second pair is a capture and a read. The bench provokes both by driving a fault strobe together with `clr_i`, and separately together with `rd_en_i`. A reference model predicts each case from the requirements. The model expects the fault to survive the clear, and it expects the read to return the pre-capture word. A scoreboard judges every cycle against both the live word and the read data.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

    localparam int CHAN_W    = 4;
    localparam int FLAG_N    = 3;
    localparam int WORD_W    = 32;

    // flag bit positions inside the status word
    localparam int F_DST     = 0;
    localparam int F_SRC     = 1;
    localparam int F_CFG     = 2;
    localparam int CHAN_LSB  = 8;
    localparam int VALID_BIT = WORD_W - 1;

    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic [FLAG_N-1:0] flags;
        logic [WORD_W-1:0] rd;
    } err_state_t;

endpackage

// File: rtl/dma_err_align.sv
module dma_err_align #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 5
) (
    input  logic              sg_start,
    input  logic              sg_en,
    input  logic [ADDR_W-1:0] link,
    output logic              cfg_err
);
    logic unused_hi;
    assign unused_hi = ^link[ADDR_W-1:ALIGN_BITS];

    always_comb begin
        cfg_err = sg_start && sg_en && (link[ALIGN_BITS-1:0] != '0);
    end
endmodule

// File: rtl/dma_err_prio.sv
module dma_err_prio #(
    parameter int N = 3
) (
    input  logic [N-1:0] raw,
    output logic [N-1:0] grant,
    output logic         any
);
    // highest index wins
    always_comb begin
        logic higher;
        higher = 1'b0;
        grant  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            grant[i] = raw[i] & ~higher;
            higher   = higher | raw[i];
        end
        any = higher;
    end
endmodule

// File: rtl/dma_err_status.sv
module dma_err_status
    import dma_err_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_err_i,
    input  logic              dst_err_i,
    input  logic              sg_start_i,
    input  logic              sg_en_i,
    input  logic [ADDR_W-1:0] sg_link_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              clr_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] status_o,
    output logic [WORD_W-1:0] rd_data_o
);
    err_state_t        st_d, st_q;
    logic              cfg_err;
    logic [FLAG_N-1:0] raw, grant;
    logic              any_err;
    logic [WORD_W-1:0] word;

    dma_err_align #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_align (
        .sg_start (sg_start_i),
        .sg_en    (sg_en_i),
        .link     (sg_link_i),
        .cfg_err  (cfg_err)
    );

    always_comb begin
        raw        = '0;
        raw[F_DST] = dst_err_i;
        raw[F_SRC] = src_err_i;
        raw[F_CFG] = cfg_err;
    end

    dma_err_prio #(.N(FLAG_N)) u_prio (
        .raw   (raw),
        .grant (grant),
        .any   (any_err)
    );

    always_comb begin
        word                              = '0;
        word[VALID_BIT]                   = st_q.valid;
        word[CHAN_LSB +: CHAN_W]          = st_q.chan;
        word[FLAG_N-1:0]                  = st_q.flags;
    end

    always_comb begin
        st_d = st_q;
        if (any_err) begin
            st_d.valid = 1'b1;
            st_d.chan  = chan_i;
            st_d.flags = grant;
        end else if (clr_i) begin
            st_d.valid = 1'b0;
            st_d.chan  = '0;
            st_d.flags = '0;
        end
        if (rd_en_i) begin
            st_d.rd = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o  = word;
    assign rd_data_o = st_q.rd;
endmodule

// File: rtl/dma_err_status_chk.sv
module dma_err_status_chk
    import dma_err_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_err_i,
    input logic              dst_err_i,
    input logic              sg_start_i,
    input logic              sg_en_i,
    input logic [ADDR_W-1:0] sg_link_i,
    input logic [CHAN_W-1:0] chan_i,
    input logic              clr_i,
    input logic              rd_en_i,
    input logic [WORD_W-1:0] status_o,
    input logic [WORD_W-1:0] rd_data_o
);
    logic misal, unused_hi;
    assign misal     = sg_start_i && sg_en_i && (sg_link_i[ALIGN_BITS-1:0] != '0);
    assign unused_hi = ^sg_link_i[ADDR_W-1:ALIGN_BITS];

    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_o[FLAG_N-1:0]) &&
        (status_o[VALID_BIT] == (status_o[FLAG_N-1:0] != '0)));

    p_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_err_i && !src_err_i && !misal) |=>
        (status_o[FLAG_N-1:0] == 3'b001) && status_o[VALID_BIT] &&
        (status_o[CHAN_LSB +: CHAN_W] == $past(chan_i)));

    p_src_r3_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_err_i && !misal) |=>
        (status_o[FLAG_N-1:0] == 3'b010) &&
        (status_o[CHAN_LSB +: CHAN_W] == $past(chan_i)));

    p_cfg_r4_r7: assert property (@(posedge clk) disable iff (!rst_n)
        misal |=> (status_o[FLAG_N-1:0] == 3'b100) && status_o[VALID_BIT]);

    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!misal && !src_err_i && !dst_err_i && !clr_i) |=> $stable(status_o));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !misal && !src_err_i && !dst_err_i) |=> (status_o == '0));

    p_clrlose_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (misal || src_err_i || dst_err_i)) |=> status_o[VALID_BIT]);

    p_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> (rd_data_o == $past(status_o)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));
endmodule

bind dma_err_status dma_err_status_chk #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (.*);

// File: tb/dma_err_status_tb.sv
`timescale 1ns/1ps
module dma_err_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_err_i = 0, dst_err_i = 0, sg_start_i = 0, sg_en_i = 0;
    logic [31:0] sg_link_i = '0;
    logic [3:0]  chan_i = '0;
    logic        clr_i = 0, rd_en_i = 0;
    logic [31:0] status_o, rd_data_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [31:0] st;
        logic [31:0] rd;
        string       req;
    } item_t;
    item_t sb[$];

    logic [31:0] m_st = '0;
    logic [31:0] m_rd = '0;

    always #2 clk = ~clk;

    dma_err_status u_dut (
        .clk(clk), .rst_n(rst_n), .src_err_i(src_err_i), .dst_err_i(dst_err_i),
        .sg_start_i(sg_start_i), .sg_en_i(sg_en_i), .sg_link_i(sg_link_i),
        .chan_i(chan_i), .clr_i(clr_i), .rd_en_i(rd_en_i),
        .status_o(status_o), .rd_data_o(rd_data_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, model prediction pushed to scoreboard
    task automatic step(input bit s, input bit d, input bit sgs, input bit sge,
                        input logic [31:0] link, input logic [3:0] ch,
                        input bit clr, input bit rd, input string req);
        item_t it;
        logic [2:0] f;
        @(negedge clk);
        src_err_i = s; dst_err_i = d; sg_start_i = sgs; sg_en_i = sge;
        sg_link_i = link; chan_i = ch; clr_i = clr; rd_en_i = rd;
        if (rd) m_rd = m_st;
        f = 3'b000;
        if (sgs && sge && link[4:0] != 5'd0) f = 3'b100;
        else if (s) f = 3'b010;
        else if (d) f = 3'b001;
        if (f != 3'b000) begin
            m_st = '0;
            m_st[31] = 1'b1;
            m_st[11:8] = ch;
            m_st[2:0] = f;
        end else if (clr) begin
            m_st = '0;
        end
        it.st = m_st; it.rd = m_rd; it.req = req;
        sb.push_back(it);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.req, status_o, it.st);
                check({it.req, "/R10"}, rd_data_o, it.rd);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset status", status_o, 32'h0);
        check("R1 reset rd", rd_data_o, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        step(0,1,0,0,32'h0,4'd3,0,0,"R2 dst");
        step(0,0,0,0,32'h0,4'd0,0,1,"R10 read dst");
        step(0,0,1,1,32'h1000_0040,4'd7,0,0,"R5 aligned link");
        step(0,0,1,0,32'h1000_0043,4'd7,0,0,"R5 enable off");
        step(0,0,1,1,32'h1000_0000,4'd7,0,1,"R5 aligned + read");
        step(1,0,0,0,32'h0,4'd9,0,0,"R3 src R6 replace");
        step(0,0,1,1,32'h2000_0010,4'd12,0,0,"R4 misaligned R6");
        step(0,0,1,1,32'h2000_0001,4'd15,0,1,"R4 low bit + read");
        step(0,0,0,0,32'h0,4'd0,1,0,"R8 clear");
        step(0,0,0,0,32'h0,4'd0,0,1,"R8 read cleared");
        step(1,1,0,0,32'h0,4'd5,0,0,"R7 src beats dst");
        step(1,1,1,1,32'h0000_0108,4'd6,0,1,"R7 cfg beats all + read");
        step(0,1,1,0,32'h0000_0108,4'd1,0,0,"R7 cfg off dst wins");
        step(0,1,0,0,32'h0,4'd2,1,0,"R9 error beats clear");
        step(1,0,0,0,32'h0,4'd4,1,1,"R9 src beats clear + R10");
        step(0,0,1,1,32'h0000_001F,4'd8,1,0,"R9 cfg beats clear");
        step(0,0,0,0,32'h0,4'd0,1,0,"R8 clear again");
        step(0,0,0,0,32'h0,4'd0,0,0,"R10 hold");
        step(0,0,0,0,32'h0,4'd0,0,1,"R10 read zero");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule